// File: doc/BRIEF.md
# Frame Header Register-Dump Line Formatter

This block produces the byte stream of the line that opens every video frame on a parallel byte-wide video interface. That line carries no pixels. It carries a snapshot of the configuration register map. A line timing controller pulses `start`. The formatter then sends a four-byte line-start sync header and two blanking bytes. Next it reads registers 0 to 63 in ascending order through a simple read port, and after every value it sends a 0x07 guard byte. Blanking bytes follow until the configured line length is reached. A four-byte line-end sync header then closes the line.

Because every register value is followed by 0x07, the three-byte reserved pattern FF, FF, 00 cannot appear anywhere in the payload. A receiver therefore only ever finds that pattern at real sync headers. Register locations the map does not implement, as given by the `IMPL_MASK` parameter, are sent as the device identification value `DEV_ID`. The read-out order is fixed and nothing outside the block can change it.

The read port is combinational. The block drives `reg_addr` with `reg_rd_en` high, and the register map returns `reg_rdata` in the same cycle, where it goes straight to the output byte. The FSM states are IDLE, SOF_HDR, PAD, REG_VAL, GUARD, BLANK, EOL_HDR and FIN. The transitions are:
- IDLE to SOF_HDR on `start`.
- SOF_HDR to PAD after four bytes.
- PAD to REG_VAL after two bytes.
- REG_VAL to GUARD always.
- GUARD to REG_VAL while registers remain, and GUARD to BLANK after the last one.
- BLANK to EOL_HDR when the byte position reaches `LINE_LEN`.
- EOL_HDR to FIN after four bytes.
- FIN to IDLE always.

Top module: `frame_hdr_fmt`

## Requirements
- R1: After reset, `out_valid`, `busy`, `done` and `reg_rd_en` are all 0.
- R2: The first output byte appears in the cycle after `start` is sampled high in IDLE. Bytes 0 to 3 of the line are FF, FF, 00, 0x80 (line-start code).
- R3: Bytes 4 and 5 of the line are the blanking value 0x07.
- R4: Byte 6+2i (i = 0 to 63) is the value of register i. That byte is read in the same cycle with `reg_rd_en`=1 and `reg_addr`=i, so the addresses are read strictly in ascending order.
- R5: Byte 7+2i, which follows each register value, is the guard value 0x07.
- R6: When bit i of `IMPL_MASK` is 0, byte 6+2i is `DEV_ID` and `reg_rdata` is not used.
- R7: Bytes 134 to `LINE_LEN`-1 are the blanking value 0x07.
- R8: Bytes `LINE_LEN` to `LINE_LEN`+3 are FF, FF, 00, 0x9D (line-end code), so a line is `LINE_LEN`+4 bytes with `out_valid` high throughout.
- R9: `busy` is high exactly while line bytes are output. `done` is high for the single cycle after the last line-end byte.
- R10: `start` has no effect while a line is in progress. Exactly one line is produced, and `out_valid` stays low after `done` until a new `start`.
- R11: The pattern FF, FF, 00 occurs in a line only at byte positions 0 and `LINE_LEN`, whatever the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to produce one frame-start line |
| busy | output | 1 | High while the line's bytes are output |
| done | output | 1 | One-cycle pulse after the line completes |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 6 | Register address being read |
| reg_rdata | input | 8 | Register value for `reg_addr`, same cycle |
| out_valid | output | 1 | Output byte is part of a line |
| out_data | output | 8 | Output byte |

## Verification
The assertions are checked on every cycle:
- A guard byte follows every register read.
- Read addresses step up by one between reads.
- A read only happens inside a line.
- `done` lasts one cycle and comes exactly when `busy` falls.
- The two padding states and the FIN state are entered only from their required predecessors.

Only the bench scenarios can show the rest. These are:
- The exact byte contents at every position.
- Default substitution against a sparse implementation mask.
- The line length.
- The absence of stray sync patterns when register values are FF and 00.
- That a mid-line `start` is ignored.

// File: rtl/fhf_pkg.sv
package fhf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF_HDR,
        ST_PAD,
        ST_REG_VAL,
        ST_GUARD,
        ST_BLANK,
        ST_EOL_HDR,
        ST_FIN
    } fhf_state_e;

    localparam logic [7:0] BLANK_BYTE = 8'h07;
    localparam logic [7:0] SYNC_HI    = 8'hFF;
    localparam logic [7:0] SYNC_LO    = 8'h00;
    localparam logic [7:0] IDLE_BYTE  = 8'h00;

endpackage

// File: rtl/fhf_sync_gen.sv
module fhf_sync_gen #(
    parameter logic [7:0] SOF_CODE = 8'h80,
    parameter logic [7:0] EOL_CODE = 8'h9D
) (
    input  logic [1:0] idx,
    input  logic       is_eol,
    output logic [7:0] sync_byte
);
    import fhf_pkg::*;

    always_comb begin
        unique case (idx)
            2'd0:    sync_byte = SYNC_HI;
            2'd1:    sync_byte = SYNC_HI;
            2'd2:    sync_byte = SYNC_LO;
            default: sync_byte = is_eol ? EOL_CODE : SOF_CODE;
        endcase
    end

endmodule

// File: rtl/fhf_reg_src.sv
module fhf_reg_src #(
    parameter int          NREG      = 64,
    parameter int          AW        = $clog2(NREG),
    parameter logic [63:0] IMPL_MASK = 64'hFFFF_FFFF_FFFF_FFFF,
    parameter logic [7:0]  DEV_ID    = 8'h56
) (
    input  logic [AW-1:0] addr,
    input  logic [7:0]    rdata,
    output logic [7:0]    value
);
    logic [NREG-1:0] impl_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_impl
        assign impl_vec[g] = IMPL_MASK[g];
    end

    always_comb begin
        value = impl_vec[addr] ? rdata : DEV_ID;
    end

endmodule

// File: rtl/fhf_ctrl.sv
module fhf_ctrl #(
    parameter int NREG     = 64,
    parameter int AW       = $clog2(NREG),
    parameter int LINE_LEN = 160,
    parameter int PW       = $clog2(LINE_LEN + 4)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output fhf_pkg::fhf_state_e     state,
    output logic [1:0]              sidx,
    output logic [AW-1:0]           ridx,
    output logic                    busy,
    output logic                    done,
    output logic                    rd_en
);
    import fhf_pkg::*;

    localparam logic [AW-1:0] LAST_REG = AW'(NREG - 1);
    localparam logic [PW-1:0] LAST_POS = PW'(LINE_LEN - 1);

    fhf_state_e    nxt;
    logic [PW-1:0] pos;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_SOF_HDR;
            ST_SOF_HDR: if (sidx == 2'd3) nxt = ST_PAD;
            ST_PAD:     if (sidx == 2'd1) nxt = ST_REG_VAL;
            ST_REG_VAL: nxt = ST_GUARD;
            ST_GUARD:   nxt = (ridx == LAST_REG) ? ST_BLANK : ST_REG_VAL;
            ST_BLANK:   if (pos == LAST_POS) nxt = ST_EOL_HDR;
            ST_EOL_HDR: if (sidx == 2'd3) nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // position and index counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sidx <= '0;
            ridx <= '0;
            pos  <= '0;
        end else begin
            if (state == ST_SOF_HDR || state == ST_PAD || state == ST_EOL_HDR)
                sidx <= (nxt != state) ? 2'd0 : sidx + 2'd1;
            else
                sidx <= '0;

            if (state == ST_IDLE)       ridx <= '0;
            else if (state == ST_GUARD) ridx <= ridx + 1'b1;

            if (state == ST_IDLE || state == ST_FIN) pos <= '0;
            else                                     pos <= pos + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy  = (state != ST_IDLE) && (state != ST_FIN);
        done  = (state == ST_FIN);
        rd_en = (state == ST_REG_VAL);
    end

    assert_pad_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && $past(state) != ST_PAD) |-> $past(state) == ST_SOF_HDR);

    assert_pad_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REG_VAL && $past(state) == ST_PAD) |-> $past(state, 2) == ST_PAD);

    assert_fin_after_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FIN |-> $past(state) == ST_EOL_HDR);

endmodule

// File: rtl/frame_hdr_fmt.sv
module frame_hdr_fmt #(
    parameter int          NREG      = 64,
    parameter int          LINE_LEN  = 160,
    parameter logic [63:0] IMPL_MASK = 64'h0FFF_00FF_F7FF_F0F3,
    parameter logic [7:0]  DEV_ID    = 8'h56,
    parameter logic [7:0]  SOF_CODE  = 8'h80,
    parameter logic [7:0]  EOL_CODE  = 8'h9D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       reg_rd_en,
    output logic [5:0] reg_addr,
    input  logic [7:0] reg_rdata,
    output logic       out_valid,
    output logic [7:0] out_data
);
    import fhf_pkg::*;

    localparam int AW = $clog2(NREG);
    localparam int PW = $clog2(LINE_LEN + 4);

    fhf_state_e    state;
    logic [1:0]    sidx;
    logic [AW-1:0] ridx;
    logic [7:0]    sync_byte;
    logic [7:0]    reg_value;

    fhf_ctrl #(
        .NREG(NREG), .AW(AW), .LINE_LEN(LINE_LEN), .PW(PW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .state(state), .sidx(sidx), .ridx(ridx),
        .busy(busy), .done(done), .rd_en(reg_rd_en)
    );

    fhf_sync_gen #(
        .SOF_CODE(SOF_CODE), .EOL_CODE(EOL_CODE)
    ) u_sync (
        .idx(sidx), .is_eol(state == ST_EOL_HDR), .sync_byte(sync_byte)
    );

    fhf_reg_src #(
        .NREG(NREG), .AW(AW), .IMPL_MASK(IMPL_MASK), .DEV_ID(DEV_ID)
    ) u_src (
        .addr(ridx), .rdata(reg_rdata), .value(reg_value)
    );

    assign reg_addr = 6'(ridx);

    always_comb begin
        out_valid = 1'b1;
        unique case (state)
            ST_SOF_HDR, ST_EOL_HDR:     out_data = sync_byte;
            ST_REG_VAL:                 out_data = reg_value;
            ST_PAD, ST_GUARD, ST_BLANK: out_data = BLANK_BYTE;
            default: begin
                out_valid = 1'b0;
                out_data  = IDLE_BYTE;
            end
        endcase
    end

    assert_guard_after_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> (out_valid && out_data == BLANK_BYTE));

    assert_ascending_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr != 6'd0) |-> ($past(reg_rd_en, 2) && $past(reg_addr, 2) == reg_addr - 6'd1));

    assert_read_inside_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (busy && out_valid));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_on_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: tb/frame_hdr_fmt_test.sv
`timescale 1ns/1ps
module frame_hdr_fmt_test;

    localparam int          LEN  = 150;
    localparam logic [63:0] MASK = 64'hF0F0_0FFF_FF3C_A5FF;
    localparam logic [7:0]  DEV  = 8'h3B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, reg_rd_en, out_valid;
    logic [5:0] reg_addr;
    logic [7:0] reg_rdata, out_data;

    int pat = 0;
    int n_vec = 0;
    int n_bad = 0;
    int k = 0;
    int stray = 0;
    bit chk_done = 1'b0;
    logic [7:0] b1 = 8'h00, b2 = 8'h00;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    frame_hdr_fmt #(
        .LINE_LEN(LEN), .IMPL_MASK(MASK), .DEV_ID(DEV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] model(int p, int a);
        case (p)
            0:       return 8'((a * 7) + 3);
            1:       return a[0] ? 8'h00 : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    assign reg_rdata = model(pat, int'(reg_addr));

    function automatic string req_of(int i);
        if (i < 4)        return "R2";
        if (i < 6)        return "R3";
        if (i < 134)      return (i % 2 == 0) ? "R4/R6" : "R5";
        if (i < LEN)      return "R7";
        return "R8";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: push expected line, then pulse start
    task automatic run_line(int p, bit poke_mid);
        pat = p;
        exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
        exp_q.push_back(8'h00); exp_q.push_back(8'h80);
        exp_q.push_back(8'h07); exp_q.push_back(8'h07);
        for (int i = 0; i < 64; i++) begin
            exp_q.push_back(MASK[i] ? model(p, i) : DEV);
            exp_q.push_back(8'h07);
        end
        for (int i = 134; i < LEN; i++) exp_q.push_back(8'h07);
        exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
        exp_q.push_back(8'h00); exp_q.push_back(8'h9D);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (poke_mid) begin
            repeat (20) @(posedge clk);
            #1 start = 1'b1;   // R10: ignored while busy
            @(posedge clk); #1 start = 1'b0;
            repeat (100) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        do @(negedge clk); while (!done);
        repeat (6) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_done) begin
                check("R9 done", {29'd0, done, busy, out_valid}, 32'd4);
                check("R11 stray sync", stray, 0);
                chk_done = 1'b0;
                stray = 0;
                k = 0;
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 extra byte", out_data, 32'hDEAD);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(req_of(k), out_data, e);
                    check("R9 busy", busy, 1);
                    if (b2 == 8'hFF && b1 == 8'hFF && out_data == 8'h00 && k >= 2
                        && (k - 2) != 0 && (k - 2) != LEN)
                        stray++;
                    b2 = b1;
                    b1 = out_data;
                    if (k == LEN + 3) chk_done = 1'b1;
                    k++;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {28'd0, out_valid, busy, done, reg_rd_en}, 32'd0);
        #1 rst_n = 1'b1;
        run_line(0, 1'b0);
        run_line(1, 1'b0);
        run_line(2, 1'b1);
        check("R10 idle after line", {31'd0, out_valid}, 0);
        check("R10 queue drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule